// File: doc/BRIEF.md
# Keyboard Wake Interrupt Controller

This block watches up to eight keyboard pins and raises one interrupt request toward the CPU when a key press pulls an enabled pin low. A per-pin enable register picks which pins take part. For each enabled pin the block also drives a pullup-enable output and a force-input output, which the surrounding pad logic uses. A control register selects one of two trigger modes, holds an interrupt mask, and accepts a software acknowledge. The pending flag stays visible whatever the mask is set to, so polling software can use it.

The pins first pass through a two-flop synchronizer. The block then takes the AND of the enabled pins, with a disabled pin counted as high. A request is latched only when that AND falls, that is, when all enabled pins were high and at least one goes low. A three-state machine holds the request:

- `ST_IDLE`: no request.
- `ST_PEND`: a request is latched and no acknowledge has been seen.
- `ST_ACKW`: in level mode, an acknowledge has been seen but an enabled pin is still low.

The transitions are:

- `IDLE->PEND`: on a fall.
- `PEND->IDLE`: on an acknowledge in edge mode, or in level mode with all pins high.
- `PEND->ACKW`: on an acknowledge in level mode while a pin is low.
- `PEND->PEND`: with no acknowledge, or when a fall happens in the same cycle as the acknowledge.
- `ACKW->IDLE`: when all pins return high, or when level mode is switched off.
- `ACKW->PEND`: on a fall.

An acknowledge comes from a vector-fetch strobe or from a software write.

Top module: `kbi_ctrl`

## Requirements
- R1: Writing address 0 loads the pin enable register. A pin whose enable bit is 0 is treated as high, so a low level on that pin never latches a request.
- R2: `pullup_en` and `force_in` both equal the enable register at all times.
- R3: A request is latched only when the synchronized AND of the enabled pins goes from 1 to 0. `pend_o` rises on the third rising clock edge after the pin changes. A pin falling while another enabled pin is already low latches nothing.
- R4: In edge mode (control bit 0 = 0), an acknowledge clears the request on the clock edge where it is seen, even while a pin is still low.
- R5: In level mode (control bit 0 = 1), the request stays asserted while any enabled pin is low, even after an acknowledge.
- R6: In level mode, the request clears only once both of these have happened, in either order: an acknowledge has been seen, and all enabled pins are high.
- R7: An acknowledge is either a one-cycle `vec_ack` pulse or a write of 1 to control bit 1 at address 1. Bit 1 is not stored. A fall after an acknowledge latches a new request.
- R8: Reset clears the pending request, the mode bit, the mask bit and the enables, even while a pin is held low.
- R9: `pend_o` shows the latched request whatever the mask is set to. `irq_o` equals `pend_o` while control bit 2 (mask) is 0, and is 0 while the mask is 1.
- R10: When a fall and an acknowledge happen in the same cycle, the fall wins and the request stays pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 8 | Keyboard pin levels (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = enable register, 1 = control register |
| wr_data | input | 8 | Write data |
| vec_ack | input | 1 | Vector-fetch acknowledge pulse |
| irq_o | output | 1 | Masked interrupt request to the CPU |
| pend_o | output | 1 | Unmasked pending flag |
| pullup_en | output | 8 | Per-pin pullup enable |
| force_in | output | 8 | Per-pin force-to-input |

## Verification
The assertions assume that `vec_ack` and software acknowledge writes are single-cycle strobes, and that reset is held for at least one edge. They also assume that pin levels stay stable for several cycles, so the synchronizer delay is the only latency between a pin change and a detected fall. The stimulus changes pins only on falling clock edges and holds each level for at least three cycles. The one exception is the same-cycle test, which times a single `vec_ack` pulse to land exactly on the edge where a fall is seen.

// File: rtl/kbi_pkg.sv
package kbi_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PEND = 2'd1,
        ST_ACKW = 2'd2
    } kbi_state_t;

    localparam int CTL_MODE_BIT = 0;
    localparam int CTL_ACK_BIT  = 1;
    localparam int CTL_MASK_BIT = 2;
    localparam int ADDR_ENABLE  = 0;
    localparam int ADDR_CTRL    = 1;
endpackage

// File: rtl/kbi_sync.sv
module kbi_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stg[g] <= '1;
                end else if (g == 0) begin
                    stg[g] <= d;
                end else begin
                    stg[g] <= stg[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/kbi_regs.sv
module kbi_regs
    import kbi_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [NPINS-1:0] wr_data,
    output logic [NPINS-1:0] en_q,
    output logic             mode_q,
    output logic             mask_q,
    output logic             sw_ack
);
    logic wr_enable_reg;
    logic wr_ctrl_reg;

    assign wr_enable_reg = wr_en && (wr_addr == 1'(ADDR_ENABLE));
    assign wr_ctrl_reg   = wr_en && (wr_addr == 1'(ADDR_CTRL));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            mode_q <= 1'b0;
            mask_q <= 1'b0;
        end else begin
            if (wr_enable_reg) begin
                en_q <= wr_data;
            end
            if (wr_ctrl_reg) begin
                mode_q <= wr_data[CTL_MODE_BIT];
                mask_q <= wr_data[CTL_MASK_BIT];
            end
        end
    end

    // The acknowledge bit is a strobe only and is not stored.
    assign sw_ack = wr_ctrl_reg && wr_data[CTL_ACK_BIT];
endmodule

// File: rtl/kbi_edge.sv
module kbi_edge #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pins_s,
    input  logic [NPINS-1:0] en,
    output logic             all_hi,
    output logic             fall
);
    logic prev_hi_q;

    // A disabled pin is treated as high in the AND.
    assign all_hi = &(pins_s | ~en);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_hi_q <= 1'b1;
        end else begin
            prev_hi_q <= all_hi;
        end
    end

    assign fall = prev_hi_q && !all_hi;
endmodule

// File: rtl/kbi_fsm.sv
module kbi_fsm
    import kbi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fall,
    input  logic ack,
    input  logic all_hi,
    input  logic level_mode,
    output logic pend,
    output logic ack_seen
);
    kbi_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (fall) state_d = ST_PEND;
            end
            ST_PEND: begin
                if (fall) begin
                    state_d = ST_PEND;
                end else if (ack) begin
                    if (!level_mode || all_hi) state_d = ST_IDLE;
                    else                       state_d = ST_ACKW;
                end
            end
            ST_ACKW: begin
                if (fall)                         state_d = ST_PEND;
                else if (all_hi || !level_mode)   state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        pend     = 1'b0;
        ack_seen = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PEND: pend = 1'b1;
            ST_ACKW: begin
                pend     = 1'b1;
                ack_seen = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/kbi_ctrl.sv
module kbi_ctrl #(
    parameter int NPINS       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [NPINS-1:0] wr_data,
    input  logic             vec_ack,
    output logic             irq_o,
    output logic             pend_o,
    output logic [NPINS-1:0] pullup_en,
    output logic [NPINS-1:0] force_in
);
    logic [NPINS-1:0] pins_s;
    logic [NPINS-1:0] en_q;
    logic             mode_q;
    logic             mask_q;
    logic             sw_ack;
    logic             ack_any;
    logic             all_hi;
    logic             fall;
    logic             ack_seen;

    kbi_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pins_s)
    );

    kbi_regs #(.NPINS(NPINS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .en_q    (en_q),
        .mode_q  (mode_q),
        .mask_q  (mask_q),
        .sw_ack  (sw_ack)
    );

    kbi_edge #(.NPINS(NPINS)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_s (pins_s),
        .en     (en_q),
        .all_hi (all_hi),
        .fall   (fall)
    );

    assign ack_any = sw_ack || vec_ack;

    kbi_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .fall       (fall),
        .ack        (ack_any),
        .all_hi     (all_hi),
        .level_mode (mode_q),
        .pend       (pend_o),
        .ack_seen   (ack_seen)
    );

    assign irq_o     = pend_o && !mask_q;
    assign pullup_en = en_q;
    assign force_in  = en_q;
endmodule

// File: rtl/kbi_chk.sv
module kbi_chk (
    input logic clk,
    input logic rst_n,
    input logic pend_o,
    input logic irq_o,
    input logic fall,
    input logic ack,
    input logic mode,
    input logic all_hi,
    input logic ack_seen
);
    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> pend_o); // R9

    AST_RISE_FROM_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_o) |-> $past(fall)); // R3

    AST_EDGE_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && ack && !fall && !mode) |=> !pend_o); // R4

    AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && mode && !all_hi) |=> pend_o); // R5

    AST_CLEAR_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend_o) |-> ($past(ack) || $past(ack_seen))); // R6

    AST_FALL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> pend_o); // R10
endmodule

bind kbi_ctrl kbi_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend_o   (pend_o),
    .irq_o    (irq_o),
    .fall     (fall),
    .ack      (ack_any),
    .mode     (mode_q),
    .all_hi   (all_hi),
    .ack_seen (ack_seen)
);

// File: tb/sim_kbi_ctrl.sv
module sim_kbi_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_in = 8'hFF;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       vec_ack = 1'b0;
    logic       irq_o, pend_o;
    logic [7:0] pullup_en, force_in;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        logic       pend;
        logic       irq;
        logic [7:0] pull;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;

    kbi_ctrl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .vec_ack   (vec_ack),
        .irq_o     (irq_o),
        .pend_o    (pend_o),
        .pullup_en (pullup_en),
        .force_in  (force_in)
    );

    task automatic expect_out(input logic p, input logic i, input logic [7:0] pl, input string tag);
        exp_t e;
        e.pend = p; e.irq = i; e.pull = pl; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic vack();
        vec_ack = 1'b1;
        @(negedge clk);
        vec_ack = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Monitor: pops each expected item and compares it to the ports.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_checks++;
                if (pend_o !== e.pend || irq_o !== e.irq ||
                    pullup_en !== e.pull || force_in !== e.pull) begin
                    n_fail++;
                    $display("FAIL %s: pend=%b irq=%b pull=%h force=%h expected pend=%b irq=%b pull=%h",
                             e.tag, pend_o, irq_o, pullup_en, force_in, e.pend, e.irq, e.pull);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        expect_out(0, 0, 8'h00, "R8 reset state");

        wr(1'b0, 8'h0F);
        expect_out(0, 0, 8'h0F, "R2 pullup/force follow enables");

        pin_in = 8'h7F; settle();
        expect_out(0, 0, 8'h0F, "R1 disabled pin low ignored");
        pin_in = 8'hFF; settle();

        // R3 latency: pin falls, request visible after three edges
        pin_in = 8'hFE;
        repeat (2) @(negedge clk);
        expect_out(0, 0, 8'h0F, "R3 no request before sync delay");
        expect_out(1, 1, 8'h0F, "R3 request after fall");

        wr(1'b1, 8'h04);
        expect_out(1, 0, 8'h0F, "R9 mask gates irq, pend visible");
        wr(1'b1, 8'h00);
        expect_out(1, 1, 8'h0F, "R9 unmasked irq");

        pin_in = 8'hFC; settle();
        wr(1'b1, 8'h02);
        expect_out(0, 0, 8'h0F, "R4 edge-mode ack clears with pin low");
        settle();
        expect_out(0, 0, 8'h0F, "R3 second pin low latches nothing");

        pin_in = 8'hFF; settle();
        pin_in = 8'hFB; settle();
        expect_out(1, 1, 8'h0F, "R3 new fall after all high");
        vack();
        expect_out(0, 0, 8'h0F, "R7 vector ack clears");
        pin_in = 8'hFF; settle();

        // Level mode
        wr(1'b1, 8'h01);
        pin_in = 8'hF7; settle();
        expect_out(1, 1, 8'h0F, "R5 level request");
        wr(1'b1, 8'h03);
        expect_out(1, 1, 8'h0F, "R5 ack while low keeps request");
        settle();
        expect_out(1, 1, 8'h0F, "R5 still held");
        pin_in = 8'hFF; settle();
        expect_out(0, 0, 8'h0F, "R6 clear after ack then release");

        pin_in = 8'hFE; settle();
        pin_in = 8'hFF; settle();
        expect_out(1, 1, 8'h0F, "R6 release alone does not clear");
        vack();
        expect_out(0, 0, 8'h0F, "R6 clear after release then ack");

        pin_in = 8'hFD; settle();
        pin_in = 8'hFF; settle();
        wr(1'b1, 8'h03);
        expect_out(0, 0, 8'h0F, "R7 software ack clears");
        pin_in = 8'hFD; settle();
        expect_out(1, 1, 8'h0F, "R7 fall after ack latches again");
        pin_in = 8'hFF; settle();
        vack();

        // R10: fall and ack in the same cycle
        wr(1'b1, 8'h00);
        pin_in = 8'hFE; settle();
        pin_in = 8'hFF; settle();
        expect_out(1, 1, 8'h0F, "R10 setup pending");
        pin_in = 8'hFE;
        repeat (2) @(negedge clk);
        vack();
        expect_out(1, 1, 8'h0F, "R10 fall wins over ack");
        vack();
        expect_out(0, 0, 8'h0F, "R10 later ack clears");
        pin_in = 8'hFF; settle();

        // R8: reset with a pin held low clears request and mode
        wr(1'b1, 8'h01);
        pin_in = 8'hFB; settle();
        expect_out(1, 1, 8'h0F, "R8 setup level pending");
        do_reset();
        expect_out(0, 0, 8'h00, "R8 reset clears with pin low");
        wr(1'b0, 8'h04);
        settle();
        expect_out(1, 1, 8'h04, "R8 enabling low pin latches");
        wr(1'b1, 8'h02);
        expect_out(0, 0, 8'h04, "R8 mode back to edge after reset");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule